// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog timer. Software picks a timeout from a fixed set of 16 interval codes and sets an enable bit. It then has to restart the countdown again and again by writing a reload command. If the countdown runs out while the watchdog is enabled and the whole-system reset action is selected, the block drives a system-reset output high for a fixed number of clock cycles. It also clears its own enable bit and records a sticky expired flag.

Writes to the two settings registers are protected by a 16-bit key that must appear in the upper half of the write data. A write without that key leaves the registers unchanged. A reload command counts only when the command bit is set and a 12-bit key sits beside it. Time is measured in half-second ticks, which a prescaler derives from a clock-frequency parameter. A small frequency value therefore shrinks a whole timeout to a few dozen cycles.

Top module: `kwd_top`

## Requirements
- R1: The reload register is at offset 0x10, the action register at 0x14 and the mode register at 0x18. A write to any other offset changes nothing, and a read of any other offset returns zero. The reload register always reads as zero.
- R2: A write to the action or mode register changes it only when write-data bits 31:16 equal 0x16AA. Bits 31:16 of every read are zero.
- R3: A write to the reload register is accepted only when bit 0 is 1 and bits 12:1 equal 0xA57. An accepted reload restarts the countdown from the current interval. Any other write to the reload register does not change when expiry occurs.
- R4: Mode register layout: bit 0 is the enable, bits 7:4 are the interval code, and bit 2 is the read-only expired flag. All other bits read as zero.
- R5: Interval codes in seconds: 0x0 is 0.5 s, 0x1 to 0x6 are 1 to 6 s, 0x7 to 0xB are 8, 10, 12, 14 and 16 s, and 0xC to 0xF are 16 s. With the watchdog enabled and no further reload, the reset output rises exactly seconds × CLK_HZ cycles after the clock edge that accepted the reload.
- R6: A new interval code written while the countdown runs does not move the pending expiry. It takes effect at the next accepted reload.
- R7: On expiry with the action field (bits 1:0 of the action register) equal to 01, the reset output is high for exactly RST_CYCLES cycles. The enable bit then reads 0 and the expired flag reads 1.
- R8: On expiry with any other action value, the reset output stays low, the enable stays 1 and the countdown restarts from the interval.
- R9: While the enable is 0 the countdown does not advance and the reset output stays low. A keyed mode write with all other bits zero stops the watchdog.
- R10: After reset all registers read zero and the reset output is low, so the watchdog is disabled with the 0.5 s interval selected.
- R11: An accepted mode write clears the expired flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register for a read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_reset_o | output | 1 | System-reset pulse on expiry |

## Verification
The bench builds the block with CLK_HZ = 8 and RST_CYCLES = 5, so one half-second tick lasts four cycles. With this setting even the 16 s interval expires after 128 cycles. That makes it practical to sweep all sixteen interval codes, measure each expiry time to the exact cycle and measure the width of every reset pulse. The short tick also lets the bench place a rejected reload, a mid-count interval change and a stream of keep-alive reloads at known points inside a single countdown.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CODE_W = 4;
    localparam int ACT_W  = 2;
    localparam int TICK_W = 6;

    localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ACTION = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h18;

    localparam logic [15:0] WR_KEY     = 16'h16AA;
    localparam logic [11:0] RELOAD_KEY = 12'hA57;

    localparam logic [ACT_W-1:0] ACT_SYS_RESET = 2'b01;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              expired;
        logic              en;
    } mode_t;

    // Number of half-second ticks for an interval code.
    function automatic logic [TICK_W-1:0] code_to_ticks(input logic [CODE_W-1:0] code);
        logic [TICK_W-1:0] c6;
        logic [TICK_W-1:0] r;
        c6 = {{(TICK_W-CODE_W){1'b0}}, code};
        if (code == 4'd0)
            r = 6'd1;
        else if (code <= 4'd6)
            r = c6 << 1;
        else if (code <= 4'd11)
            r = (c6 << 2) - 6'd12;
        else
            r = 6'd32;
        return r;
    endfunction

endpackage

// File: rtl/kwd_regfile.sv
module kwd_regfile
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fire,
    output mode_t             mode,
    output logic [ACT_W-1:0]  action,
    output logic              reload
);

    logic keyed;
    logic hit_reload, hit_action, hit_mode;

    assign keyed      = (wdata[31:16] == WR_KEY);
    assign hit_reload = (addr == OFF_RELOAD);
    assign hit_action = (addr == OFF_ACTION);
    assign hit_mode   = (addr == OFF_MODE);

    assign reload = wr && hit_reload && wdata[0] && (wdata[12:1] == RELOAD_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            action <= '0;
        end else begin
            if (wr && hit_action && keyed)
                action <= wdata[ACT_W-1:0];
            if (fire) begin
                mode.en      <= 1'b0;
                mode.expired <= 1'b1;
            end else if (wr && hit_mode && keyed) begin
                mode.en      <= wdata[0];
                mode.code    <= wdata[7:4];
                mode.expired <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_action)
            rdata[ACT_W-1:0] = action;
        else if (hit_mode) begin
            rdata[0]   = mode.en;
            rdata[2]   = mode.expired;
            rdata[7:4] = mode.code;
        end
    end

    AST_NOKEY_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_mode && !keyed && !fire) |=> ($stable(mode.en) && $stable(mode.code))) // R2
        else $error("unkeyed mode write changed mode");

    AST_NOKEY_ACTION_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_action && !keyed) |=> $stable(action)) // R2
        else $error("unkeyed action write changed action");

    AST_FIRE_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!mode.en && mode.expired)) // R7
        else $error("expiry did not clear enable");

endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
    parameter int HALF_CYC = 12_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(HALF_CYC - 1);

    logic [PW-1:0] pre;

    assign tick = run && (pre == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || tick)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre == '0)) // R9
        else $error("prescaler advanced while stopped");

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              reload,
    input  logic [CODE_W-1:0] code,
    output logic [TICK_W-1:0] cnt,
    output logic              lapse
);

    logic [TICK_W-1:0] load_val;

    assign load_val = code_to_ticks(code);
    assign lapse    = tick && !reload && (cnt == 6'd1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= 6'd1;
        else if (reload || lapse)
            cnt <= load_val;
        else if (tick)
            cnt <= cnt - 1'b1;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> $stable(cnt)) // R9
        else $error("countdown moved while disabled");

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0)) // R5
        else $error("countdown reached zero");

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (fire)
            left <= LOAD;
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign active = (left != '0);

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int CLK_HZ     = 24_000_000,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_reset_o
);

    localparam int HALF_CYC = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;

    mode_t             mode;
    logic [ACT_W-1:0]  action;
    logic              reload;
    logic              tick;
    logic              lapse;
    logic              fire;
    logic [TICK_W-1:0] cnt;

    assign fire = lapse && (action == ACT_SYS_RESET);

    kwd_regfile i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .fire   (fire),
        .mode   (mode),
        .action (action),
        .reload (reload)
    );

    kwd_prescale #(.HALF_CYC(HALF_CYC)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (mode.en),
        .restart (reload),
        .tick    (tick)
    );

    kwd_countdown i_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (mode.en),
        .tick   (tick),
        .reload (reload),
        .code   (mode.code),
        .cnt    (cnt),
        .lapse  (lapse)
    );

    kwd_pulse #(.LEN(RST_CYCLES)) i_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .active (sys_reset_o)
    );

    AST_RESET_NEEDS_ACTION: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_o) |-> ($past(action) == ACT_SYS_RESET)) // R8
        else $error("reset pulse without system-reset action");

    AST_BADKEY_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_RELOAD && bus_wdata[12:1] != RELOAD_KEY && !tick)
            |=> $stable(cnt)) // R3
        else $error("reload with bad key restarted count");

    AST_RESET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_reset_o) |-> $past(mode.en)) // R7
        else $error("reset pulse while disabled");

endmodule

// File: tb/test_kwd_top.sv
`timescale 1ns/1ps
module test_kwd_top;

    localparam int HZ   = 8;
    localparam int HALF = HZ / 2;
    localparam int PW   = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sys_reset_o;

    int cyc = 0;
    int wr_edge = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kwd_top #(.CLK_HZ(HZ), .RST_CYCLES(PW)) i_kwd_top (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_reset_o (sys_reset_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        wr_edge = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_rst(input int maxc, output int edge_n);
        edge_n = -1;
        if (sys_reset_o) begin
            edge_n = cyc;
            return;
        end
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (sys_reset_o) begin
                edge_n = cyc;
                return;
            end
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (sys_reset_o) begin
            w++;
            @(negedge clk);
        end
    endtask

    function automatic int half_secs(input int c);
        if (c == 0) return 1;
        if (c <= 6) return 2 * c;
        if (c <= 11) return 4 * c - 12;
        return 32;
    endfunction

    localparam logic [31:0] KEY = 32'h16AA_0000;
    localparam logic [31:0] GOOD_RELOAD = 32'h0000_14AF;

    task automatic main_seq();
        logic [31:0] v;
        int e, w, start;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(8'h18, v); chk("R10 mode after reset", v, 0);
        rd(8'h14, v); chk("R10 action after reset", v, 0);
        chk("R10 reset output low", sys_reset_o, 0);
        // R1 reload register and unmapped offset
        rd(8'h10, v); chk("R1 reload reads zero", v, 0);
        wr(8'h1C, KEY | 32'h71);
        rd(8'h1C, v); chk("R1 unmapped reads zero", v, 0);
        rd(8'h18, v); chk("R1 unmapped write no effect", v, 0);
        // R2 unkeyed writes ignored
        wr(8'h18, 32'h0000_0071);
        rd(8'h18, v); chk("R2 unkeyed mode ignored", v, 0);
        wr(8'h18, 32'h16AB_0071);
        rd(8'h18, v); chk("R2 wrong key mode ignored", v, 0);
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, v); chk("R2 unkeyed action ignored", v, 0);
        wr(8'h14, KEY | 32'h1);
        rd(8'h14, v); chk("R2 keyed action, key reads zero", v, 1);

        // R5 R7 R11 sweep over every interval code
        for (int c = 0; c < 16; c++) begin
            wr(8'h18, KEY | (32'(c) << 4) | 32'h1);
            rd(8'h18, v); chk("R4 mode readback", v, (c << 4) | 1);
            wr(8'h10, GOOD_RELOAD);
            start = wr_edge;
            wait_rst(200, e);
            chk($sformatf("R5 expiry delay code %0d", c), e - start, half_secs(c) * HALF);
            pulse_width(w);
            chk("R7 pulse width", w, PW);
            rd(8'h18, v); chk("R7 enable cleared, expired set", v, (c << 4) | 4);
            wr(8'h18, KEY);
            rd(8'h18, v); chk("R11 keyed write clears expired", v, 0);
        end

        // R3 rejected reloads do not move expiry (code 2 -> 16 cycles)
        wr(8'h18, KEY | 32'h21);
        wr(8'h10, GOOD_RELOAD);
        start = wr_edge;
        wr(8'h10, 32'h0000_14AD);
        wr(8'h10, 32'h0000_14AE);
        wr(8'h10, 32'h0000_0001);
        wait_rst(200, e);
        chk("R3 bad reloads ignored", e - start, 16);
        pulse_width(w);

        // R3 a second good reload restarts the count
        wr(8'h18, KEY | 32'h21);
        wr(8'h10, GOOD_RELOAD);
        repeat (5) @(negedge clk);
        wr(8'h10, GOOD_RELOAD);
        start = wr_edge;
        wait_rst(200, e);
        chk("R3 good reload restarts count", e - start, 16);
        pulse_width(w);

        // R6 interval change pends until next reload
        wr(8'h18, KEY | 32'h21);
        wr(8'h10, GOOD_RELOAD);
        start = wr_edge;
        wr(8'h18, KEY | 32'hB1);
        wait_rst(200, e);
        chk("R6 old interval still used", e - start, 16);
        pulse_width(w);
        wr(8'h18, KEY | 32'hB1);
        wr(8'h10, GOOD_RELOAD);
        start = wr_edge;
        wait_rst(300, e);
        chk("R6 new interval after reload", e - start, 128);
        pulse_width(w);

        // R3 keep-alive reloads prevent expiry (code 1 -> 8 cycles)
        wr(8'h18, KEY | 32'h11);
        for (int k = 0; k < 8; k++) begin
            wr(8'h10, GOOD_RELOAD);
            repeat (3) @(negedge clk);
        end
        chk("R3 keep-alive holds reset low", sys_reset_o, 0);
        // R9 stop then idle
        wr(8'h18, KEY);
        wait_rst(100, e);
        chk("R9 stopped watchdog no reset", e, -1);
        rd(8'h18, v); chk("R9 stopped mode reads zero", v, 0);

        // R8 other action: no reset, enable kept, repeats
        wr(8'h14, KEY | 32'h2);
        wr(8'h18, KEY | 32'h01);
        wr(8'h10, GOOD_RELOAD);
        wait_rst(60, e);
        chk("R8 no reset with other action", e, -1);
        rd(8'h18, v); chk("R8 enable stays set", v, 1);
        // switch to system reset; countdown restarted, expiry within a tick
        wr(8'h14, KEY | 32'h1);
        wait_rst(20, e);
        chk("R8 count kept running", (e != -1) ? 1 : 0, 1);
        pulse_width(w);
        chk("R7 pulse width after R8", w, PW);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule